// File: doc/BRIEF.md
# Start-Kicked Watchdog Supervisor

This block supervises a processor through one active-high reset output. The processor shows that it is alive by taking part in ordinary two-wire bus traffic. Each bus start condition on the raw clock and data lines counts as a service event, so no dedicated service pin is needed. A start condition is a data line falling while the clock line is high. A down-counter runs on a slow timebase tick and is reloaded by every service event. If the counter runs out, the block drives reset.

Reset is also held at power-up and whenever the digital supply-good input is low. It is released only after supply-good has stayed high, without a break, for a fixed number of ticks. A timeout reset lasts for the same hold time. A two-bit period code picks one of three timeout lengths, or turns the timeout off. The tick input comes from an external prescaler, so the defaults in ticks (1750, 750, 250 and a hold of 250) give real-time values with a 1 ms tick. A simulation can use smaller values.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_n` is sampled low, `sys_rst_o` is 1, and it stays 1 after `rst_n` returns high until the hold of R2 completes.
- R2: With `pwr_good_i` high, `sys_rst_o` falls after exactly `HOLD` ticks have been consumed while the hold is active.
- R3: When `pwr_good_i` is sampled low, `sys_rst_o` is 1 from the next cycle on. The hold count restarts from zero, so release needs `HOLD` uninterrupted ticks after the last rise of `pwr_good_i`.
- R4: Period code `wd_sel_i` 2'b00 selects `P_LONG` ticks, 2'b01 selects `P_MID` ticks and 2'b10 selects `P_SHORT` ticks. Without a service event, `sys_rst_o` rises after exactly that many ticks following the last reload.
- R5: Period code 2'b11 disables the timeout: the counter stays idle and no timeout reset is ever raised.
- R6: A start condition reloads the counter with the full selected period. A start condition is a 1-to-0 change of `sda_i` while `scl_i` is 1, after two-flop synchronization. A fall of `sda_i` while `scl_i` is 0 does not reload the counter.
- R7: A start condition that arrives while `sys_rst_o` is 1 has no effect: the hold still lasts exactly `HOLD` ticks.
- R8: A timeout reset lasts `HOLD` ticks. After its release the counter starts again from the full selected period.
- R9: Any change of `wd_sel_i` reloads the counter with the newly selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse from an external prescaler |
| scl_i | input | 1 | Raw, asynchronous bus clock line |
| sda_i | input | 1 | Raw, asynchronous bus data line |
| pwr_good_i | input | 1 | Supply-good flag, synchronous to `clk` |
| wd_sel_i | input | 2 | Timeout period code (see R4, R5) |
| sys_rst_o | output | 1 | Active-high supervised reset output |

## Verification
The in-line properties check these rules on every cycle:
- the counter never goes above the longest period;
- no timeout fires while disabled or while the hold is active;
- a supply drop or a timeout asserts the hold in the next cycle;
- the hold is released only on a tick with supply good;
- a detected start condition lasts exactly one cycle.

Some behaviours can only be shown by the bench's scenarios, because they depend on exact tick counts over long windows. These are the timeout length for each code, the hold length after power-up, after a supply glitch and after a timeout, and the reload on a code change. The same holds for the proof that false data-line edges do not service the timer while real start conditions do.

// File: rtl/wdg_pkg.sv
// Package: shared types for the start-kicked watchdog supervisor.
// Assumes: period codes are decoded only by wdg_countdown.
package wdg_pkg;
    typedef enum logic [1:0] {
        PER_LONG  = 2'b00,
        PER_MID   = 2'b01,
        PER_SHORT = 2'b10,
        PER_OFF   = 2'b11
    } wd_period_e;
endpackage

// File: rtl/wdg_start_detect.sv
// Module: wdg_start_detect
// Synchronizes the raw bus clock/data lines and emits a one-cycle pulse on
// each start condition (data falling while clock is high).
// Assumes: lines idle high; synchronizer depth STAGES >= 2.
module wdg_start_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Purpose: metastability chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Purpose: start condition = data fell while clock stayed high.
    always_comb begin
        start_o = scl_d && scl_sh[STAGES-1] && sda_d && !sda_sh[STAGES-1];
    end

    // R6: a start pulse never lasts more than one cycle
    p_single_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/wdg_hold_timer.sv
// Module: wdg_hold_timer
// Holds the reset active until supply-good has been high for HOLD
// consecutive ticks; re-arms on supply loss or on a watchdog expiry.
// Assumes: pg_i is already synchronous to clk; HOLD >= 1.
module wdg_hold_timer #(
    parameter int HOLD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pg_i,
    input  logic expire_i,
    output logic active_o
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] cnt;

    // Purpose: hold state and tick count toward release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b1;
            cnt      <= '0;
        end else if (!pg_i || expire_i) begin
            active_o <= 1'b1;
            cnt      <= '0;
        end else if (active_o && tick_i) begin
            if (cnt == HW'(HOLD - 1)) begin
                active_o <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: loss of supply asserts reset in the next cycle
    p_pg_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> active_o);
    // R2: release happens only on a tick consumed with supply good
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> ($past(pg_i) && $past(tick_i)));
    // R8: a watchdog expiry starts a hold
    p_expire_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> active_o);
endmodule

// File: rtl/wdg_countdown.sv
// Module: wdg_countdown
// Tick-driven down-counter with selectable period. It reloads on a service
// event, on a period-code change and during hold, and pulses expire_o when
// it runs out.
// Assumes: P_LONG >= P_MID >= P_SHORT >= 1.
module wdg_countdown
    import wdg_pkg::*;
#(
    parameter int P_LONG  = 1750,
    parameter int P_MID   = 750,
    parameter int P_SHORT = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic       hold_i,
    input  wd_period_e sel_i,
    output logic       expire_o
);
    localparam int CW = $clog2(P_LONG + 1);

    logic [CW-1:0] cnt;
    wd_period_e    sel_q;

    function automatic logic [CW-1:0] period_of(wd_period_e s);
        case (s)
            PER_LONG:  return CW'(P_LONG);
            PER_MID:   return CW'(P_MID);
            PER_SHORT: return CW'(P_SHORT);
            default:   return '0;
        endcase
    endfunction

    // Purpose: reload/decrement the timeout and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sel_q    <= PER_OFF;
            expire_o <= 1'b0;
        end else begin
            sel_q    <= sel_i;
            expire_o <= 1'b0;
            if (hold_i || sel_i == PER_OFF || sel_i != sel_q || kick_i) begin
                cnt <= period_of(sel_i);
            end else if (tick_i) begin
                if (cnt <= CW'(1)) begin
                    expire_o <= 1'b1;
                    cnt      <= period_of(sel_i);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R5: a disabled watchdog never expires
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == PER_OFF) |=> !expire_o);
    // R7: no expiry is raised while a hold is in progress
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !expire_o);
    // R4: counter never exceeds the longest period
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(P_LONG));
endmodule

// File: rtl/wdg_supervisor.sv
// Module: wdg_supervisor (top)
// Watchdog supervisor kicked by bus start conditions, with a power-good
// reset hold. sys_rst_o is active high.
// Assumes: tick_i is a one-cycle pulse; pwr_good_i and wd_sel_i are
// synchronous to clk; scl_i/sda_i are raw asynchronous lines.
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int P_LONG      = 1750,
    parameter int P_MID       = 750,
    parameter int P_SHORT     = 250,
    parameter int HOLD        = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       pwr_good_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o
);
    logic kick;
    logic expire;
    logic hold;

    wdg_start_detect #(.STAGES(SYNC_STAGES)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (kick)
    );

    wdg_countdown #(.P_LONG(P_LONG), .P_MID(P_MID), .P_SHORT(P_SHORT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kick_i   (kick),
        .hold_i   (hold),
        .sel_i    (wd_period_e'(wd_sel_i)),
        .expire_o (expire)
    );

    wdg_hold_timer #(.HOLD(HOLD)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .pg_i     (pwr_good_i),
        .expire_i (expire),
        .active_o (hold)
    );

    // Purpose: drive the supervised reset from the hold state.
    always_comb begin
        sys_rst_o = hold;
    end
endmodule

// File: tb/sim_wdg_supervisor.sv
module sim_wdg_supervisor;
    localparam int PL = 35, PM = 15, PS = 5, HD = 6;
    localparam int NV = 5;
    // {sel[9:8], expected ticks[7:0]}; 0 = never times out
    localparam logic [9:0] VEC [NV] = '{
        {2'b00, 8'd35}, {2'b01, 8'd15}, {2'b10, 8'd5}, {2'b11, 8'd0}, {2'b10, 8'd5}};

    logic clk = 0, rst_n = 0, tick = 0, scl = 1, sda = 1, pg = 1;
    logic [1:0] sel = 2'b11;
    logic sys_rst;
    int n_chk = 0, n_bad = 0, phase = 0;
    logic rst_seen = 0;

    wdg_supervisor #(.P_LONG(PL), .P_MID(PM), .P_SHORT(PS), .HOLD(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl), .sda_i(sda),
        .pwr_good_i(pg), .wd_sel_i(sel), .sys_rst_o(sys_rst));

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk); #2;
            tick = (phase == 3);
            phase = (phase + 1) % 4;
        end
    end

    initial forever begin
        @(negedge clk);
        if (sys_rst) rst_seen = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic until_rise(output int n);
        n = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (sys_rst) break;
            if (tick) n++;
        end
    endtask

    task automatic during_rst(output int n);
        n = 0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (!sys_rst) break;
            if (tick) n++;
        end
    endtask

    task automatic kick;
        step(3); sda = 0; step(3); scl = 0; step(2); sda = 1; step(2); scl = 1; step(2);
    endtask

    task automatic fake_edge;
        scl = 0; step(2); sda = 0; step(3); sda = 1; step(2); scl = 1; step(2);
    endtask

    task automatic set_sel(input logic [1:0] s);
        step(1); sel = s; @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int n, h;
        step(5);
        @(negedge clk);
        check(sys_rst == 1, "R1 reset state", sys_rst, 1);
        step(1); rst_n = 1;
        during_rst(h);
        check(h == HD, "R2 power-up hold", h, HD);

        // table-driven period codes
        for (int i = 0; i < NV; i++) begin
            set_sel(VEC[i][9:8]);
            if (VEC[i][7:0] == 0) begin
                rst_seen = 0;
                step(4 * 3 * PL);
                check(rst_seen == 0, "R5 disabled no reset", rst_seen, 0);
            end else begin
                until_rise(n);
                check(n == int'(VEC[i][7:0]), "R4 timeout length", n, VEC[i][7:0]);
                during_rst(h);
                check(h == HD, "R8 timeout hold", h, HD);
            end
        end

        // R6: real starts keep it alive, false edges do not
        rst_seen = 0;
        repeat (8) kick();
        check(rst_seen == 0, "R6 kicks prevent timeout", rst_seen, 0);
        rst_seen = 0;
        repeat (4) fake_edge();
        check(rst_seen == 1, "R6 sda fall with scl low ignored", rst_seen, 1);
        while (sys_rst) @(negedge clk);

        // R7/R8: kicks during hold ignored; full period afterwards
        until_rise(n);
        fork
            begin during_rst(h); until_rise(n); end
            begin kick(); kick(); end
        join
        check(h == HD, "R7 kicks during hold ignored", h, HD);
        check(n == PS, "R8 full period after hold", n, PS);
        while (sys_rst) @(negedge clk);

        // R9: code change reloads with new period
        set_sel(2'b00);
        repeat (40) @(negedge clk);
        set_sel(2'b10);
        until_rise(n);
        check(n == PS, "R9 reload on code change", n, PS);
        while (sys_rst) @(negedge clk);

        // R3: supply loss and glitch restart
        set_sel(2'b00);
        step(8); pg = 0;
        @(negedge clk); @(negedge clk);
        check(sys_rst == 1, "R3 reset on supply loss", sys_rst, 1);
        step(80);
        @(negedge clk);
        check(sys_rst == 1, "R3 held while supply low", sys_rst, 1);
        step(1); pg = 1;
        during_rst(h);
        check(h == HD, "R3 hold after supply return", h, HD);
        step(1); pg = 0; step(2); pg = 1; step(12); pg = 0; step(2); pg = 1;
        during_rst(h);
        check(h == HD, "R3 glitch restarts hold", h, HD);

        // R5: disabled long run
        set_sel(2'b11);
        rst_seen = 0;
        step(400);
        check(rst_seen == 0, "R5 disabled long run", rst_seen, 0);

        // R1: reset mid-run
        step(1); rst_n = 0; step(1);
        @(negedge clk);
        check(sys_rst == 1, "R1 reset mid-run", sys_rst, 1);
        finish_run();
    end
endmodule